// File: doc/BRIEF.md
# Loopback Packet Client with Frozen Statistics

This block drives and watches traffic for a loopback test of an Ethernet MAC. On command it sends a fixed burst of packets on a valid/ready streaming transmit port. Each packet is a fixed number of 8-byte beats with start and end markers, and the payload is an incrementing beat index. A receive port of the same style, with no back-pressure, is monitored. For each direction the block keeps three 64-bit event counters: beats that carry the start marker, beats that carry the end marker, and beats that carry the error marker.

Software controls the block through a small 32-bit register port with one-cycle read latency. A single control word starts the burst, freezes a coherent copy of all six counters so that their 32-bit halves can be read without tearing, and with a one-shot clear bit aborts the burst and zeroes every counter. After a complete loopback run, both directions report the burst size in their start and end counters and zero errors.

Top module: `pkt_client_stats`

## Requirements
- R1: After reset `tx_valid` is 0, the control word at offset 0x00 reads 0 and every counter word reads 0.
- R2: The control word at 0x00 holds a run flag in bit 0 and a freeze flag in bit 6, and both read back as written. Bit 8 is a one-shot clear that always reads 0. A write that takes bit 0 from 0 to 1 without bit 8 starts one burst of 16 packets. After the burst, a new burst needs bit 0 to be written to 0 and then back to 1.
- R3: Each packet is 8 beats. `tx_sop` is set on the first beat only and `tx_eop` on the last beat only. `tx_err` is always 0. `tx_data` equals the number of beats already accepted since the burst started, beginning at 0.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_data` hold. Stalls never drop or repeat a beat.
- R5: The counters are placed as follows: TX start 0x20, TX end 0x28, TX error 0x30, RX start 0x38, RX end 0x40, RX error 0x48. A TX counter rises by 1 in each cycle with `tx_valid && tx_ready` and its marker set. An RX counter rises by 1 in each cycle with `rx_valid` and its marker set. A marker that arrives without valid is not counted.
- R6: Each counter is 64 bits wide. The low word is at the listed offset and the high word at offset+4.
- R7: A control write that takes bit 6 from 0 to 1 copies all six counters in that same clock edge. While bit 6 stays 1, counter reads return that copy even as traffic continues. With bit 6 at 0, reads return the live values.
- R8: A control write with bit 8 set stops transmission, so `tx_valid` is 0 from the next cycle. The same write zeroes all live and frozen counters and leaves bit 0 at 0.
- R9: A read of any offset other than 0x00 and the twelve counter words returns 0.
- R10: `reg_rdata` takes the addressed value on the clock edge where `reg_rd_en` is 1 and holds its value in all other cycles.
- R11: With `tx_*` looped back to `rx_*` and a full burst sent, the TX and RX start and end counters all read 16 and both error counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd_en` |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit beat accepted |
| tx_data | output | DATA_W | Transmit payload (beat index) |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| tx_err | output | 1 | Transmit error marker (never set) |
| rx_valid | input | 1 | Receive beat valid |
| rx_sop | input | 1 | Receive first-beat marker |
| rx_eop | input | 1 | Receive last-beat marker |
| rx_err | input | 1 | Receive error marker |

## Verification
The burst is sent once with `tx_ready` held high and once with a stall every third cycle. Equal counts in both runs, together with an unbroken data sequence, show that stalls neither lose nor repeat beats. A freeze taken partway through a burst separates a real copy from a live view: two reads of the same word are identical while the live value has moved on. Hand-made receive beats that mix error, start and end markers, including markers without valid, show that each counter watches only its own marker. A clear issued during a burst shows that traffic stops and that all counters, live and frozen, return to zero.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SNAP_BIT = 6;
    localparam int CTRL_CLR_BIT  = 8;

    localparam logic [7:0] OFS_CTRL     = 8'h00;
    localparam logic [7:0] OFS_CNT_BASE = 8'h20;

    localparam int NUM_DIR  = 2;   // 0 = transmit, 1 = receive
    localparam int NUM_KIND = 3;   // 0 = start, 1 = end, 2 = error
    localparam int NUM_SLOT = NUM_DIR * NUM_KIND;

    typedef enum logic {
        GEN_IDLE,
        GEN_SEND
    } gen_state_e;

    typedef struct packed {
        logic err;
        logic eop;
        logic sop;
    } mark_t;

    typedef struct packed {
        logic       hit_ctrl;
        logic       hit_cnt;
        logic [2:0] slot;
        logic       hi;
    } dec_t;

    function automatic dec_t decode(input logic [7:0] a);
        dec_t       d;
        logic [7:0] off;
        off        = a - OFS_CNT_BASE;
        d.hit_ctrl = (a == OFS_CTRL);
        d.hit_cnt  = (a >= OFS_CNT_BASE) && (off < 8'(NUM_SLOT * 8)) && (a[1:0] == 2'b00);
        d.slot     = off[5:3];
        d.hi       = off[2];
        return d;
    endfunction

endpackage

// File: rtl/pc_gen.sv
module pc_gen
    import pc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PKTS   = 16,
    parameter int BEATS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output mark_t             tx_mark
);

    localparam int PW = (PKTS  > 1) ? $clog2(PKTS)  : 1;
    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

    gen_state_e        state;
    logic [PW-1:0]     pkt;
    logic [BW-1:0]     beat;
    logic [DATA_W-1:0] seq;
    logic              last_beat;
    logic              last_pkt;

    assign last_beat = (beat == BW'(BEATS - 1));
    assign last_pkt  = (pkt  == PW'(PKTS - 1));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state <= GEN_IDLE;
            pkt   <= '0;
            beat  <= '0;
            seq   <= '0;
        end else begin
            case (state)
                GEN_IDLE: begin
                    if (start) begin
                        state <= GEN_SEND;
                        pkt   <= '0;
                        beat  <= '0;
                        seq   <= '0;
                    end
                end
                GEN_SEND: begin
                    if (tx_ready) begin
                        seq <= seq + 1'b1;
                        if (last_beat) begin
                            beat <= '0;
                            if (last_pkt) state <= GEN_IDLE;
                            else          pkt   <= pkt + 1'b1;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                default: state <= GEN_IDLE;
            endcase
        end
    end

    assign tx_valid    = (state == GEN_SEND);
    assign tx_data     = seq;
    assign tx_mark.sop = (beat == '0);
    assign tx_mark.eop = last_beat;
    assign tx_mark.err = 1'b0;

endmodule

// File: rtl/pc_cnt_bank.sv
module pc_cnt_bank
    import pc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic             beat,
    input  mark_t            mark,
    output logic [CNT_W-1:0] live [NUM_KIND],
    output logic [CNT_W-1:0] copy [NUM_KIND]
);

    logic [NUM_KIND-1:0] hit;
    assign hit = {mark.err, mark.eop, mark.sop};

    for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                live[k] <= '0;
                copy[k] <= '0;
            end else begin
                if (beat && hit[k]) live[k] <= live[k] + 1'b1;
                if (take)           copy[k] <= live[k];
            end
        end
    end

endmodule

// File: rtl/pkt_client_stats.sv
module pkt_client_stats
    import pc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 64,
    parameter int PKTS   = 16,
    parameter int BEATS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              tx_err,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic              rx_err
);

    logic  run_q;
    logic  snap_q;
    logic  ctrl_wr;
    logic  clr_p;
    logic  take_p;
    logic  start_p;
    mark_t tx_mark;
    mark_t rx_mark;

    assign ctrl_wr = reg_wr_en && (reg_addr == OFS_CTRL);
    assign clr_p   = ctrl_wr && reg_wdata[CTRL_CLR_BIT];
    assign take_p  = ctrl_wr && reg_wdata[CTRL_SNAP_BIT] && !snap_q;
    assign start_p = ctrl_wr && reg_wdata[CTRL_RUN_BIT] && !reg_wdata[CTRL_CLR_BIT] && !run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            snap_q <= 1'b0;
        end else if (ctrl_wr) begin
            run_q  <= reg_wdata[CTRL_RUN_BIT] && !reg_wdata[CTRL_CLR_BIT];
            snap_q <= reg_wdata[CTRL_SNAP_BIT];
        end
    end

    pc_gen #(.DATA_W(DATA_W), .PKTS(PKTS), .BEATS(BEATS)) u_gen (
        .clk      (clk),
        .rst      (rst),
        .start    (start_p),
        .abort    (clr_p),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_mark  (tx_mark)
    );

    assign tx_sop = tx_mark.sop;
    assign tx_eop = tx_mark.eop;
    assign tx_err = tx_mark.err;

    assign rx_mark.sop = rx_sop;
    assign rx_mark.eop = rx_eop;
    assign rx_mark.err = rx_err;

    logic             dir_beat  [NUM_DIR];
    mark_t            dir_mark  [NUM_DIR];
    logic [CNT_W-1:0] bank_live [NUM_DIR][NUM_KIND];
    logic [CNT_W-1:0] bank_copy [NUM_DIR][NUM_KIND];
    logic [63:0]      live_all  [8];
    logic [63:0]      copy_all  [8];

    assign dir_beat[0] = tx_valid && tx_ready;
    assign dir_mark[0] = tx_mark;
    assign dir_beat[1] = rx_valid;
    assign dir_mark[1] = rx_mark;

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        pc_cnt_bank #(.CNT_W(CNT_W)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_p),
            .take (take_p),
            .beat (dir_beat[g]),
            .mark (dir_mark[g]),
            .live (bank_live[g]),
            .copy (bank_copy[g])
        );
        for (genvar k = 0; k < NUM_KIND; k++) begin : g_flat
            assign live_all[g*NUM_KIND+k] = 64'(bank_live[g][k]);
            assign copy_all[g*NUM_KIND+k] = 64'(bank_copy[g][k]);
        end
    end

    for (genvar s = NUM_SLOT; s < 8; s++) begin : g_pad
        assign live_all[s] = '0;
        assign copy_all[s] = '0;
    end

    dec_t        dec;
    logic [63:0] sel;
    logic [31:0] rd_word;
    logic [31:0] ctrl_view;

    always_comb begin
        ctrl_view                = '0;
        ctrl_view[CTRL_RUN_BIT]  = run_q;
        ctrl_view[CTRL_SNAP_BIT] = snap_q;
    end

    always_comb begin
        dec     = decode(reg_addr);
        sel     = snap_q ? copy_all[dec.slot] : live_all[dec.slot];
        rd_word = '0;
        if (dec.hit_ctrl)      rd_word = ctrl_view;
        else if (dec.hit_cnt)  rd_word = dec.hi ? sel[63:32] : sel[31:0];
    end

    always_ff @(posedge clk) begin
        if (rst)            reg_rdata <= '0;
        else if (reg_rd_en) reg_rdata <= rd_word;
    end

endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [7:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_sop,
    input logic              tx_eop,
    input logic              tx_err
);

    logic clr_wr;
    logic mapped;

    assign clr_wr = reg_wr_en && (reg_addr == 8'h00) && reg_wdata[8];
    assign mapped = (reg_addr == 8'h00) ||
                    ((reg_addr >= 8'h20) && (reg_addr <= 8'h4C) && (reg_addr[1:0] == 2'b00));

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !clr_wr) |=> (tx_valid && $stable(tx_data))) // R4
        else $error("tx beat changed while stalled");

    AST_MARK_SANE: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (!(tx_sop && tx_eop) && !tx_err)) // R3
        else $error("bad transmit markers");

    AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> !tx_valid) // R8
        else $error("transmit not stopped by clear");

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && !mapped) |=> (reg_rdata == 32'h0)) // R9
        else $error("unmapped read not zero");

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_en |=> $stable(reg_rdata)) // R10
        else $error("read data moved without a read");

endmodule

bind pkt_client_stats pc_checker #(.DATA_W(DATA_W)) u_pc_checker (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_sop    (tx_sop),
    .tx_eop    (tx_eop),
    .tx_err    (tx_err)
);

// File: tb/tb_pkt_client_stats.sv
module tb_pkt_client_stats;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 64;
    localparam int NBEATS     = 16 * 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr_en = 1'b0;
    logic              reg_rd_en = 1'b0;
    logic [7:0]        reg_addr  = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              tx_valid;
    logic              tx_ready = 1'b1;
    logic [DATA_W-1:0] tx_data;
    logic              tx_sop, tx_eop, tx_err;
    logic              rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, rx_err = 1'b0;

    int   n_checks = 0;
    int   n_fails  = 0;
    logic loop_en  = 1'b1;
    logic bp_en    = 1'b0;
    int   bp_cnt   = 0;
    logic inj_v = 1'b0, inj_s = 1'b0, inj_e = 1'b0, inj_r = 1'b0;
    int   mon_n    = 0;
    int   mon_bad  = 0;
    int   hold_bad = 0;
    int   stalls   = 0;
    logic              prev_stall = 1'b0;
    logic [DATA_W-1:0] prev_data  = '0;

    pkt_client_stats dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_err(tx_err),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // loopback or injected receive beats
    always @(posedge clk) begin
        rx_valid <= loop_en ? (tx_valid && tx_ready) : inj_v;
        rx_sop   <= loop_en ? tx_sop : inj_s;
        rx_eop   <= loop_en ? tx_eop : inj_e;
        rx_err   <= loop_en ? tx_err : inj_r;
    end

    // back-pressure pattern
    always @(negedge clk) begin
        tx_ready <= bp_en ? ((bp_cnt % 3) != 0) : 1'b1;
        bp_cnt   <= bp_cnt + 1;
    end

    // transmit monitor: format and stall behaviour (R3, R4)
    always @(posedge clk) begin
        if (!rst) begin
            if (prev_stall && (!tx_valid || tx_data !== prev_data)) hold_bad++;
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            if (tx_valid && !tx_ready) stalls++;
            if (tx_valid && tx_ready) begin
                if (tx_data !== DATA_W'(mon_n) || tx_sop !== ((mon_n % 8) == 0) ||
                    tx_eop !== ((mon_n % 8) == 7) || tx_err !== 1'b0) mon_bad++;
                mon_n++;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd64(input logic [7:0] a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(a + 8'h4, hi);
        v = {hi, lo};
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (mon_n >= NBEATS && !tx_valid) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic start_burst();
        wr(8'h00, 32'h100);
        @(negedge clk);
        mon_n = 0; mon_bad = 0; hold_bad = 0; stalls = 0;
        wr(8'h00, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 tx_valid after reset", 64'(tx_valid), 64'h0);
        rd(8'h00, d); chk("R1 control after reset", 64'(d), 64'h0);
        rd(8'h20, d); chk("R1 TX start low after reset", 64'(d), 64'h0);
        rd(8'h4C, d); chk("R1 RX error high after reset", 64'(d), 64'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(8'h00, 32'h40);
        rd(8'h00, d); chk("R2 control readback freeze", 64'(d), 64'h40);
        chk("R2 no burst without run bit", 64'(tx_valid), 64'h0);
        wr(8'h00, 32'h0);
        rd(8'h04, d); chk("R9 unmapped 0x04", 64'(d), 64'h0);
        rd(8'h50, d); chk("R9 unmapped 0x50", 64'(d), 64'h0);
        rd(8'h22, d); chk("R9 unaligned 0x22", 64'(d), 64'h0);
        wr(8'h00, 32'h41);
        rd(8'h00, d); chk("R10 read returns control", 64'(d), 64'h41);
        wr(8'h00, 32'h100);
        repeat (3) @(negedge clk);
        chk("R10 read data held without read", 64'(reg_rdata), 64'h41);
        rd(8'h00, d); chk("R2 clear bit reads 0", 64'(d), 64'h0);
    endtask

    task automatic check_counts(input string tag);
        logic [63:0] v;
        wr(8'h00, 32'h40);
        rd64(8'h20, v); chk({tag, " R11 TX start"}, v, 64'd16);
        rd64(8'h28, v); chk({tag, " R11 TX end"},   v, 64'd16);
        rd64(8'h30, v); chk({tag, " R11 TX error"}, v, 64'd0);
        rd64(8'h38, v); chk({tag, " R11 RX start"}, v, 64'd16);
        rd64(8'h40, v); chk({tag, " R11 RX end"},   v, 64'd16);
        rd64(8'h48, v); chk({tag, " R11 RX error"}, v, 64'd0);
        wr(8'h00, 32'h0);
        chk({tag, " R3 beat count"}, 64'(mon_n), 64'(NBEATS));
        chk({tag, " R3 format and data"}, 64'(mon_bad), 64'h0);
    endtask

    task automatic t_burst_full();
        loop_en = 1'b1; bp_en = 1'b0;
        start_burst();
        wait_done();
        check_counts("full-rate");
    endtask

    task automatic t_burst_bp();
        loop_en = 1'b1; bp_en = 1'b1;
        start_burst();
        wait_done();
        bp_en = 1'b0;
        chk("R4 stalls occurred", 64'(stalls > 0), 64'h1);
        chk("R4 beat held during stall", 64'(hold_bad), 64'h0);
        check_counts("stalled");
    endtask

    task automatic t_snapshot();
        logic [31:0] a, b, c;
        logic [63:0] v;
        loop_en = 1'b1; bp_en = 1'b0;
        start_burst();
        repeat (20) @(negedge clk);
        wr(8'h00, 32'h41);
        rd(8'h20, a);
        repeat (30) @(negedge clk);
        rd(8'h20, b);
        chk("R7 frozen value stable", 64'(b), 64'(a));
        chk("R7 frozen mid-burst", 64'((a > 0) && (a < 16)), 64'h1);
        rd(8'h24, c); chk("R6 frozen high word", 64'(c), 64'h0);
        wait_done();
        rd(8'h20, b); chk("R7 still frozen after burst", 64'(b), 64'(a));
        wr(8'h00, 32'h01);
        rd64(8'h20, v); chk("R7 live after release", v, 64'd16);
    endtask

    task automatic t_rx_markers();
        logic [63:0] v;
        loop_en = 1'b0;
        wr(8'h00, 32'h100);
        @(negedge clk); inj_v = 1; inj_s = 1; inj_e = 0; inj_r = 1;
        @(negedge clk); inj_v = 1; inj_s = 0; inj_e = 0; inj_r = 1;
        @(negedge clk); inj_v = 0; inj_s = 1; inj_e = 1; inj_r = 1;
        @(negedge clk); inj_v = 1; inj_s = 0; inj_e = 1; inj_r = 0;
        @(negedge clk); inj_v = 0; inj_s = 0; inj_e = 0; inj_r = 0;
        repeat (3) @(negedge clk);
        rd64(8'h38, v); chk("R5 RX start", v, 64'd1);
        rd64(8'h40, v); chk("R5 RX end", v, 64'd1);
        rd64(8'h48, v); chk("R5 RX error", v, 64'd2);
        rd64(8'h20, v); chk("R5 TX start untouched", v, 64'd0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        logic [63:0] v;
        loop_en = 1'b0;
        @(negedge clk); inj_v = 1; inj_r = 1;
        @(negedge clk); inj_v = 0; inj_r = 0;
        wr(8'h00, 32'h41);
        repeat (12) @(negedge clk);
        chk("R8 burst running before clear", 64'(tx_valid), 64'h1);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h100;
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk("R8 tx_valid low after clear", 64'(tx_valid), 64'h0);
        repeat (5) @(negedge clk);
        chk("R8 no restart after clear", 64'(tx_valid), 64'h0);
        rd(8'h00, d); chk("R8 run bit cleared", 64'(d), 64'h0);
        rd64(8'h20, v); chk("R8 TX start zeroed", v, 64'd0);
        rd64(8'h48, v); chk("R8 RX error zeroed", v, 64'd0);
        wr(8'h00, 32'h40);
        rd64(8'h20, v); chk("R8 frozen copy zeroed", v, 64'd0);
        wr(8'h00, 32'h0);
        loop_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_burst_full();
        t_burst_bp();
        t_snapshot();
        t_rx_markers();
        t_clear();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule